// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block builds one system clock from three free-running sources: a fast primary oscillator, a slow secondary oscillator and an internal oscillator. A two-bit select input names the wanted source. When the select changes, the running source is first gated low on one of its own falling edges. The new source then waits out a fixed count of its own rising edges and is released on one of its own falling edges. The output therefore never carries a shortened high or low phase.

Each source has its own channel, clocked by that source. A channel learns the select, the sleep request and the activity of the other channels through two-flop synchronisers in its own domain. It may leave idle only when every other channel is idle. Once a channel has started its pause count, it finishes that count and is ungated before it reacts to a newer selection. A sleep request removes every source from the target set, so the output stops. A combinational busy flag covers the whole hand-over.

Top module: `clk_src_switch`

## Requirements
- R1: src_sel selects the source as follows: 2'b00 primary, 2'b01 secondary, 2'b10 and 2'b11 internal. Once a switch completes, clk_out runs at the period of the selected source.
- R2: While rst_n is low (synchronous, active low, held for several cycles of the slowest source), clk_out stays low. After release, the first rising edge of clk_out is the 12th rising edge of the selected source.
- R3: Every high phase of clk_out is a complete high phase of one source. No low phase is shorter than the shortest low phase of the sources. No channel leaves idle while another channel is active.
- R4: After the old source's last falling edge on clk_out, the next rising edge of clk_out is the 12th rising edge of the new source. That count is two edges to synchronise, one edge to start, eight counted edges, and the release on a falling edge.
- R5: switch_busy rises as soon as src_sel (or sleep_req) changes the target. It stays high until the new source is ungated and the old one is idle, and it is low in steady state.
- R6: If a selection arrives while a channel is counting its pause, that channel completes its switch and delivers at least one full high phase. The newest selection is applied only after that.
- R7: While sleep_req is high, clk_out stops low within a few cycles of the running source and switch_busy falls. On release, clk_out resumes on the 12th rising edge of the selected source after the release.
- R8: Changing src_sel between 2'b10 and 2'b11 has no effect: there is no pause, switch_busy stays low and the period is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Synchronous active-low reset, sampled in every source domain |
| clk_pri | input | 1 | Primary oscillator clock |
| clk_sec | input | 1 | Secondary low-frequency oscillator clock |
| clk_int | input | 1 | Internal oscillator clock |
| src_sel | input | 2 | Source select: 00 primary, 01 secondary, 1x internal |
| sleep_req | input | 1 | High stops all output clocking |
| clk_out | output | 1 | Switched system clock |
| switch_busy | output | 1 | High while a hand-over or stop is in progress |

## Verification
The bench measures every high and low phase of clk_out in real time. A design that ungated in the middle of a phase, or let two channels overlap, would show a high phase that matches no source. It also times each pause from the old clock's last fall, or from a reset or sleep release, against the 12-edge rule, which would catch an off-by-one pause counter or a missing synchroniser stage. A selection is changed in the middle of a count: a design that dropped the half-finished switch would emit no high phase of the secondary clock. A design that decoded 2'b11 apart from 2'b10 would raise busy or pause the clock when the select moves between those two codes.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock source switch.
// Assumes exactly three sources ordered primary, secondary, internal.
package csw_pkg;
    localparam int CSW_NSRC = 3;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_ON    = 2'd2
    } ch_state_e;

    // Map the two-bit select to a one-hot source vector (bit0 primary).
    function automatic logic [CSW_NSRC-1:0] csw_decode(input logic [1:0] sel);
        logic [CSW_NSRC-1:0] oh;
        case (sel)
            2'b00:   oh = 3'b001;
            2'b01:   oh = 3'b010;
            default: oh = 3'b100;
        endcase
        return oh;
    endfunction
endpackage

// File: rtl/csw_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchroniser, cleared by synchronous reset.
// Assumes STAGES >= 2 and that each input bit is independent.
module csw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/csw_channel.sv
`timescale 1ns/1ps
// One source channel, clocked entirely by its own source clock.
// Leaves idle only when wanted and all other channels are idle,
// counts PAUSE_EDGES rising edges, then ungates on a falling edge.
// A started count always completes before a drop of "want" is honoured.
// Assumes rst_n is held low for several cycles of this clock.
module csw_channel
    import csw_pkg::*;
#(
    parameter int PAUSE_EDGES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic want_async,
    input  logic others_async,
    output logic gated_clk,
    output logic active,
    output logic gate_on
);
    localparam int CW = $clog2(PAUSE_EDGES + 1);

    logic [1:0]    sync_q;
    logic          want_s;
    logic          others_s;
    ch_state_e     state;
    logic [CW-1:0] cnt;
    logic          gate_en;

    csw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     ({want_async, others_async}),
        .q     (sync_q)
    );
    assign want_s   = sync_q[1];
    assign others_s = sync_q[0];

    // Hand-over sequencer: idle -> pause count -> running.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                CH_IDLE: begin
                    if (want_s && !others_s) begin
                        state <= CH_COUNT;
                        cnt   <= CW'(1);
                    end
                end
                CH_COUNT: begin
                    if (cnt == CW'(PAUSE_EDGES)) begin
                        state <= CH_ON;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                CH_ON: begin
                    if (!want_s) state <= CH_IDLE;
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

    // Gate enable changes only while the source clock is low.
    always_ff @(negedge clk_src) begin
        if (!rst_n) gate_en <= 1'b0;
        else        gate_en <= (state == CH_ON);
    end

    assign gated_clk = clk_src & gate_en;
    assign active    = (state != CH_IDLE) | gate_en;
    assign gate_on   = gate_en;

    // R4: the pause counter never passes its limit.
    assert_count_bound_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
        cnt <= CW'(PAUSE_EDGES));

    // R4: no output from this source while it is still counting.
    assert_gated_in_pause_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == CH_COUNT) |-> !gate_en);

    // R6: a started count is never abandoned.
    assert_finish_switch_R6: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == CH_COUNT) |=> (state != CH_IDLE));

    // R3: never leave idle while another channel is seen active.
    assert_wait_others_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == CH_IDLE && others_s) |=> (state == CH_IDLE));

    // R7: an idle channel is gated off by the next cycle.
    assert_idle_gated_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == CH_IDLE) |=> !gate_en);
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
// Glitch-free three-way clock source switch with a sleep gate.
// One channel per source; each channel waits for all others to go
// idle, so at most one source is ever ungated. switch_busy is a
// combinational status built from the channels' flop outputs.
// Assumes rst_n is held low for several cycles of the slowest source.
module clk_src_switch
    import csw_pkg::*;
#(
    parameter int PAUSE_EDGES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       rst_n,
    input  logic       clk_pri,
    input  logic       clk_sec,
    input  logic       clk_int,
    input  logic [1:0] src_sel,
    input  logic       sleep_req,
    output logic       clk_out,
    output logic       switch_busy
);
    localparam int NSRC = CSW_NSRC;

    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] target_oh;
    logic [NSRC-1:0] others;
    logic [NSRC-1:0] active;
    logic [NSRC-1:0] gate_on;
    logic [NSRC-1:0] gated;

    assign src_clk = {clk_int, clk_sec, clk_pri};

    // Target source: none while sleeping, else the decoded select.
    always_comb target_oh = sleep_req ? '0 : csw_decode(src_sel);

    for (genvar g = 0; g < NSRC; g++) begin : g_ch
        localparam logic [NSRC-1:0] SELF = NSRC'(1) << g;
        assign others[g] = |(active & ~SELF);

        csw_channel #(
            .PAUSE_EDGES (PAUSE_EDGES),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_ch (
            .clk_src      (src_clk[g]),
            .rst_n        (rst_n),
            .want_async   (target_oh[g]),
            .others_async (others[g]),
            .gated_clk    (gated[g]),
            .active       (active[g]),
            .gate_on      (gate_on[g])
        );
    end

    assign clk_out = |gated;

    // Busy while the target is not yet ungated or another source is still live.
    always_comb switch_busy = (|(target_oh & ~gate_on)) | (|(active & ~target_oh));
endmodule

// File: tb/sim_clk_src_switch.sv
`timescale 1ns/1ps
module sim_clk_src_switch;
    logic       rst_n = 1'b0;
    logic       clk_pri = 1'b0;
    logic       clk_sec = 1'b0;
    logic       clk_int = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       sleep_req = 1'b0;
    logic       clk_out;
    logic       switch_busy;

    int checks = 0;
    int fails  = 0;

    always #2.5  clk_pri = ~clk_pri;   // 200 MHz primary
    always #18.5 clk_sec = ~clk_sec;
    always #6.5  clk_int = ~clk_int;

    clk_src_switch u0 (
        .rst_n       (rst_n),
        .clk_pri     (clk_pri),
        .clk_sec     (clk_sec),
        .clk_int     (clk_int),
        .src_sel     (src_sel),
        .sleep_req   (sleep_req),
        .clk_out     (clk_out),
        .switch_busy (switch_busy)
    );

    // {sel[1:0], expected source index[1:0]}
    localparam logic [3:0] VEC [6] = '{4'b01_01, 4'b10_10, 4'b00_00,
                                       4'b11_10, 4'b01_01, 4'b00_00};

    function automatic real per_of(input int i);
        case (i)
            0:       return 5.0;
            1:       return 37.0;
            default: return 13.0;
        endcase
    endfunction

    function automatic bit near(input real a, input real b);
        return (a > b - 0.05) && (a < b + 0.05);
    endfunction

    // Output phase monitor.
    real t_rise = -1.0;
    real t_fall = -1.0;
    real pause_gap = 0.0;
    real lp = 0.0;
    real hp = 0.0;
    int  pause_count = 0;
    int  rise_cnt = 0;
    int  bad_phase = 0;
    int  sec_highs = 0;

    always @(posedge clk_out) begin
        if (t_fall >= 0.0) begin
            lp = $realtime - t_fall;
            if (lp < 2.45) bad_phase++;
            if (lp > 40.0) begin
                pause_gap = lp;
                pause_count++;
            end
        end
        t_rise = $realtime;
        rise_cnt++;
    end

    always @(negedge clk_out) begin
        if (t_rise >= 0.0) begin
            hp = $realtime - t_rise;
            if (!(near(hp, 2.5) || near(hp, 18.5) || near(hp, 6.5))) bad_phase++;
            if (near(hp, 18.5)) sec_highs++;
        end
        t_fall = $realtime;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%f expected=%f", tag, what, act, exp);
        end
    endtask

    task automatic measure_period(output real p);
        real t1;
        @(posedge clk_out);
        t1 = $realtime;
        @(posedge clk_out);
        p = $realtime - t1;
    endtask

    task automatic do_switch(input logic [1:0] s, input int idx);
        int  pc0;
        real p;
        real gap;
        real per;
        pc0 = pause_count;
        p = per_of(idx);
        #0.3 src_sel = s;
        #0.7;
        check(switch_busy == 1'b1, "R5", "busy after select change", real'(switch_busy), 1.0);
        wait (switch_busy == 1'b0);
        wait (pause_count > pc0);
        gap = pause_gap;
        check(gap > 11.0 * p - 0.05 && gap <= 12.0 * p + 0.05, "R4",
              "pause length", gap, 12.0 * p);
        measure_period(per);
        check(near(per, p), "R1", "period after switch", per, p);
        #0.4;
        check(switch_busy == 1'b0, "R5", "busy in steady state", real'(switch_busy), 0.0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        real t_rel;
        real gap;
        real per;
        int  pc0;
        int  sh0;
        int  rc0;
        bit  busy_seen;

        // R2: output held low through reset.
        for (int k = 0; k < 4; k++) begin
            #47.3;
            check(clk_out == 1'b0, "R2", "clk_out low in reset", real'(clk_out), 0.0);
        end
        @(negedge clk_pri);
        #0.4;
        t_rel = $realtime;
        rst_n = 1'b1;
        @(posedge clk_out);
        gap = $realtime - t_rel;
        check(gap > 55.0 - 0.05 && gap <= 60.05, "R2", "first edge after reset", gap, 57.5);
        measure_period(per);
        check(near(per, 5.0), "R1", "primary period after reset", per, 5.0);

        // Table of selections walked in order.
        for (int v = 0; v < 6; v++) begin
            do_switch(VEC[v][3:2], int'(VEC[v][1:0]));
        end

        // R6: new selection arrives mid-count; secondary still completes.
        sh0 = sec_highs;
        pc0 = pause_count;
        #0.3 src_sel = 2'b01;
        #250.0 src_sel = 2'b10;
        #1.0;
        wait (switch_busy == 1'b0);
        wait (pause_count >= pc0 + 2);
        check(sec_highs - sh0 >= 1, "R6", "secondary high phases during superseded switch",
              real'(sec_highs - sh0), 1.0);
        gap = pause_gap;
        check(gap > 143.0 - 0.05 && gap <= 156.05, "R4", "pause into internal", gap, 150.0);
        measure_period(per);
        check(near(per, 13.0), "R6", "internal applied after superseded switch", per, 13.0);

        // R8: 10 -> 11 keeps the internal source with no pause.
        #2.0;
        pc0 = pause_count;
        busy_seen = 1'b0;
        src_sel = 2'b11;
        for (int k = 0; k < 150; k++) begin
            #1.0;
            if (switch_busy) busy_seen = 1'b1;
        end
        check(!busy_seen, "R8", "busy on 10->11", real'(busy_seen), 0.0);
        check(pause_count == pc0, "R8", "pause on 10->11", real'(pause_count - pc0), 0.0);
        measure_period(per);
        check(near(per, 13.0), "R8", "period after 10->11", per, 13.0);

        // R7: sleep stops the clock, wake restarts with the pause.
        #0.3 sleep_req = 1'b1;
        #100.0;
        rc0 = rise_cnt;
        #300.0;
        check(rise_cnt == rc0, "R7", "edges while asleep", real'(rise_cnt - rc0), 0.0);
        check(clk_out == 1'b0, "R7", "clk_out low asleep", real'(clk_out), 0.0);
        check(switch_busy == 1'b0, "R7", "busy after stop", real'(switch_busy), 0.0);
        @(negedge clk_int);
        #1.0;
        t_rel = $realtime;
        sleep_req = 1'b0;
        @(posedge clk_out);
        gap = $realtime - t_rel;
        check(gap > 143.0 - 0.05 && gap <= 156.05, "R7", "wake delay", gap, 150.0);

        // R3: no runt phase anywhere in the run.
        #200.0;
        check(bad_phase == 0, "R3", "runt or mismatched phases", real'(bad_phase), 0.0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule